// File: doc/BRIEF.md
# Banked Interrupt Controller with Priority Encode

This block gathers 64 interrupt sources into two banks of 32 and presents them to a processor through a small register window of 0x40 bytes. For each source, software controls an enable bit and clears latched edge events through an acknowledge register. A fixed group of sources in the low bank is level-sensitive: their pending state follows the live, synchronised input rather than a latch. All other sources are edge-triggered and record a rising edge only while they are already enabled.

The block drives a single combined request line. It also drives a registered 6-bit index, with a valid flag, of the pending enabled source of highest priority. A processor or a parent controller reads this index to dispatch without scanning the registers. The priority order puts the upper bank first, and inside a bank the higher-numbered source first. Register access is a single-cycle write and a read whose data appears one cycle later.

Top module: `pic_banked_ctrl`

## Requirements
- R1: After a synchronous reset, every enable bit and every latched event bit is zero, and `irq_o` and `irq_idx_vld` are low.
- R2: A write to a bank's enable register stores the word exactly, and a later read of that register returns it unchanged.
- R3: An edge source (any source outside the level group) sets its event bit when its synchronised input rises while its enable bit is already set. Without that enable, the event bit stays zero.
- R4: Setting the enable bit of an edge source whose input is already high latches no event and raises no request.
- R5: A write to the ack register clears each event bit whose written bit is one. Bits written as zero leave their event bits as they are.
- R6: Bank 0 sources 20 to 28 (mask 0x1ff00000) are level-sensitive. While enabled, they are pending exactly while their synchronised input is high. They never latch an event, and acknowledge writes do not affect them. Bank 1 has no level sources.
- R7: A read of a bank's level register returns the synchronised input of all 32 of its sources, whatever their enable state.
- R8: The index reports the pending source in the upper bank (sources 32 to 63) with the highest number. If the upper bank has none pending, it reports the lower bank's pending source with the highest number. The value is bank*32 + bit.
- R9: A source is pending when it is enabled and either its event bit is set or it is a level source with its input high. `irq_o` and `irq_idx_vld` are high exactly when at least one source is pending.
- R10: If an ack write clears a source's event bit in the same cycle that a new qualifying edge on that source arrives, the event bit stays set.
- R11: The address map uses byte offsets. Sources 0–31 sit at 0x20 and sources 32–63 at 0x10. Within a bank, +0x0 is event, +0x4 is enable, +0x8 is ack and +0xC is level. Ack reads as zero, and unmapped offsets read as zero. Writes to the event or level register have no effect.
- R12: `irq_o`, `irq_idx` and `irq_idx_vld` are registered. They reflect a change in pending state at the clock edge after the one that caused that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 64 | Raw interrupt inputs, bit n is source n |
| bus_addr | input | 6 | Byte address in the register window |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data, bit n is source n of the bank |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Combined interrupt request |
| irq_idx | output | 6 | Index of the highest-priority pending source |
| irq_idx_vld | output | 1 | Index is meaningful |

## Verification
An acknowledge write and a new rising edge on the same source can land on the same clock edge. The harmful outcome is that the clear erases an interrupt that has only just arrived. The bench leaves an old event latched, then raises the input so that the synchronised edge is detected exactly in the cycle the ack write is sampled. It counts the synchroniser stages to find that cycle. The test passes if the event bit reads back set afterwards and the index still names the source. A follow-up ack with no edge must then clear the bit.

// File: rtl/pic_pkg.sv
// Package: shared sizes, register selector and address helpers for the
// banked interrupt controller. Assumes two banks of 32 sources.
package pic_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int ADDR_W    = 6;

    // Register selector inside one bank, decoded from address bits [3:2]
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } pic_reg_e;

    // Address bits [5:4] that select bank b: bank 0 at 0x20, bank 1 at 0x10
    function automatic logic [1:0] bank_tag(input int b);
        return 2'(2 - b);
    endfunction
endpackage

// File: rtl/pic_sync.sv
// Module: multi-stage input synchroniser for a vector of asynchronous
// sources. Assumes each bit is independent (no bus coherency needed).
module pic_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_i;
                end
            end else begin : g_next
                // Later stages shift the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pic_bank.sv
// Module: one bank of 32 sources. Holds enable and event registers,
// detects rising edges on synchronised inputs, and forms the pending
// vector. Assumes the caller decodes the bank address and strobes.
module pic_bank
    import pic_pkg::*;
#(
    parameter int               W          = BANK_W,
    parameter int               SYNC_STG   = 2,
    parameter logic [W-1:0]     LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_raw,
    input  logic         wr_stb,
    input  pic_reg_e     wr_sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_o,
    output logic [W-1:0] ev_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] lvl;
    logic [W-1:0] lvl_d;
    logic [W-1:0] en_q;
    logic [W-1:0] ev_q;
    logic [W-1:0] rise;
    logic [W-1:0] ev_set;
    logic [W-1:0] ev_clr;

    pic_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (src_raw),
        .q_o  (lvl)
    );

    // Delay the synchronised level by one cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    // Edge set (edge sources only, gated by the current enable) and ack clear
    always_comb begin
        rise   = lvl & ~lvl_d;
        ev_set = rise & en_q & ~LEVEL_MASK;
        ev_clr = (wr_stb && wr_sel == REG_ACK) ? wdata : '0;
    end

    // Enable register: plain store of the written word
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr_stb && wr_sel == REG_ENABLE) en_q <= wdata;
    end

    // Event latch: a new edge wins over a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~ev_clr) | ev_set;
    end

    // Pending: latched events plus live level sources, under enable
    always_comb begin
        pend_o = (ev_q | (lvl & LEVEL_MASK)) & en_q;
    end

    assign en_o  = en_q;
    assign ev_o  = ev_q;
    assign lvl_o = lvl;
endmodule

// File: rtl/pic_prio.sv
// Module: registered priority encoder. Picks the highest set bit of the
// flattened pending vector, which equals upper-bank-first then
// highest-bit-first. Assumes the upper bank occupies the upper bits.
module pic_prio #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o,
    output logic             irq_o
);
    logic [IDX_W-1:0] idx_n;
    logic             any_n;

    // Scan upward so the highest set bit is the last one kept
    always_comb begin
        idx_n = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) idx_n = IDX_W'(i);
        end
        any_n = |pend_i;
    end

    // Register the index, its valid flag and the request line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
            vld_o <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            idx_o <= idx_n;
            vld_o <= any_n;
            irq_o <= any_n;
        end
    end
endmodule

// File: rtl/pic_banked_ctrl.sv
// Module: top of the banked interrupt controller. Decodes the 0x40-byte
// register window, instantiates one bank per 32 sources and the
// priority encoder, and returns read data one cycle after a read strobe.
// Assumes word-aligned accesses; address bits [1:0] are ignored.
module pic_banked_ctrl
    import pic_pkg::*;
#(
    parameter int                          SYNC_STG    = 2,
    parameter logic [NUM_SRC-1:0]          LEVEL_MASKS = {32'h0000_0000, 32'h1ff0_0000}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BANK_W-1:0]    bus_wdata,
    output logic [BANK_W-1:0]    bus_rdata,
    output logic                 irq_o,
    output logic [IDX_W-1:0]     irq_idx,
    output logic                 irq_idx_vld
);
    logic [BANK_W-1:0]  en_b   [NUM_BANKS];
    logic [BANK_W-1:0]  ev_b   [NUM_BANKS];
    logic [BANK_W-1:0]  lvl_b  [NUM_BANKS];
    logic [BANK_W-1:0]  pend_b [NUM_BANKS];
    logic [NUM_BANKS-1:0] hit;
    logic [NUM_SRC-1:0] pend_all;
    logic [NUM_SRC-1:0] ev_all;
    logic [NUM_SRC-1:0] en_all;
    logic [BANK_W-1:0]  rd_val;
    pic_reg_e           reg_sel;

    assign reg_sel = pic_reg_e'(bus_addr[3:2]);

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign hit[b] = (bus_addr[5:4] == bank_tag(b));

            pic_bank #(
                .W         (BANK_W),
                .SYNC_STG  (SYNC_STG),
                .LEVEL_MASK(LEVEL_MASKS[b*BANK_W +: BANK_W])
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_raw(src_in[b*BANK_W +: BANK_W]),
                .wr_stb (bus_wr && hit[b]),
                .wr_sel (reg_sel),
                .wdata  (bus_wdata),
                .en_o   (en_b[b]),
                .ev_o   (ev_b[b]),
                .lvl_o  (lvl_b[b]),
                .pend_o (pend_b[b])
            );

            assign pend_all[b*BANK_W +: BANK_W] = pend_b[b];
            assign ev_all  [b*BANK_W +: BANK_W] = ev_b[b];
            assign en_all  [b*BANK_W +: BANK_W] = en_b[b];
        end
    endgenerate

    // Read multiplexer: selected bank register, ack and unmapped read zero
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (hit[i]) begin
                case (reg_sel)
                    REG_EVENT:  rd_val = ev_b[i];
                    REG_ENABLE: rd_val = en_b[i];
                    REG_LEVEL:  rd_val = lvl_b[i];
                    default:    rd_val = '0;
                endcase
            end
        end
    end

    // Read data register, loaded on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    pic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend_i(pend_all),
        .idx_o (irq_idx),
        .vld_o (irq_idx_vld),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/pic_banked_chk.sv
// Checker: temporal properties of the banked interrupt controller,
// attached to the top through bind. Assumes default level masks.
module pic_banked_chk #(
    parameter logic [63:0] LVL_ALL = {32'h0000_0000, 32'h1ff0_0000}
) (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] pend_all,
    input logic [63:0] ev_all,
    input logic [63:0] en_all,
    input logic [5:0]  irq_idx,
    input logic        irq_idx_vld,
    input logic        irq_o,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_wdata
);
    // R2: a bank-0 enable write is stored exactly
    p_enable_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[5:2] == 4'b1001) |=> (en_all[31:0] == $past(bus_wdata)));

    // R3: no event bit appears on a source that was disabled the cycle before
    p_event_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_all & ~$past(ev_all) & ~$past(en_all)) == 64'd0));

    // R6: level sources never hold a latched event
    p_level_no_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_all & LVL_ALL) == 64'd0);

    // R9: valid and request follow whether anything was pending one cycle before
    p_vld_tracks_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_idx_vld == ($past(pend_all) != 64'd0)) && (irq_o == irq_idx_vld));

    // R8: the reported index is the highest pending bit
    p_idx_highest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_idx_vld |-> (($past(pend_all) >> irq_idx) == 64'd1)));
endmodule

bind pic_banked_ctrl pic_banked_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_all   (pend_all),
    .ev_all     (ev_all),
    .en_all     (en_all),
    .irq_idx    (irq_idx),
    .irq_idx_vld(irq_idx_vld),
    .irq_o      (irq_o),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata)
);

// File: tb/tb_pic_banked_ctrl.sv
// Bench: directed scenarios, one task each, checking at the ports.
module tb_pic_banked_ctrl;
    localparam logic [5:0] A0_EV = 6'h20, A0_EN = 6'h24, A0_ACK = 6'h28, A0_LV = 6'h2C;
    localparam logic [5:0] A1_EV = 6'h10, A1_EN = 6'h14, A1_ACK = 6'h18, A1_LV = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [5:0]  irq_idx;
    logic        irq_idx_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pic_banked_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, tag, 64'(v), 64'(exp));
    endtask

    task automatic chk_irq(input bit vld, input logic [5:0] idx, input string tag);
        chk(irq_o == vld && irq_idx_vld == vld, {tag, " irq/vld"}, 64'({irq_o, irq_idx_vld}), 64'({vld, vld}));
        if (vld) chk(irq_idx == idx, {tag, " idx"}, 64'(irq_idx), 64'(idx));
    endtask

    task automatic t_reset;
        chk_irq(1'b0, 6'd0, "R1 reset");
        chk_rd(A0_EN, 32'h0, "R1 enable0 after reset");
        chk_rd(A1_EN, 32'h0, "R1 enable1 after reset");
        chk_rd(A0_EV, 32'h0, "R1 event0 after reset");
    endtask

    task automatic t_enable_rb;
        wr(A0_EN, 32'hA5A5_0F0F);
        chk_rd(A0_EN, 32'hA5A5_0F0F, "R2 enable0 readback");
        wr(A1_EN, 32'h8000_0001);
        chk_rd(A1_EN, 32'h8000_0001, "R2 enable1 readback");
        wr(A0_EN, 32'h0);
        wr(A1_EN, 32'h0);
        chk_rd(A0_EN, 32'h0, "R2 enable0 cleared");
    endtask

    task automatic t_edge_ack;
        wr(A0_EN, 32'h8);
        src_in[3] = 1'b1;
        idle(6);
        chk_rd(A0_EV, 32'h8, "R3 edge latched");
        chk_irq(1'b1, 6'd3, "R3 edge request");
        wr(A0_ACK, 32'h0);
        chk_rd(A0_EV, 32'h8, "R5 zero ack keeps event");
        wr(A0_ACK, 32'h8);
        idle(2);
        chk_rd(A0_EV, 32'h0, "R5 ack clears event");
        chk_irq(1'b0, 6'd0, "R5 request dropped");
        src_in[3] = 1'b0;
        wr(A0_EN, 32'h0);
        idle(4);
    endtask

    task automatic t_pre_high;
        src_in[5] = 1'b1;
        idle(6);
        wr(A0_EN, 32'h20);
        idle(4);
        chk_rd(A0_EV, 32'h0, "R4 no event when enabled high");
        chk_irq(1'b0, 6'd0, "R4 no request");
        src_in[5] = 1'b0;
        idle(4);
        src_in[5] = 1'b1;
        idle(6);
        chk_rd(A0_EV, 32'h20, "R3 later edge latched");
        chk_irq(1'b1, 6'd5, "R3 later edge request");
        wr(A0_ACK, 32'h20);
        src_in[5] = 1'b0;
        wr(A0_EN, 32'h0);
        idle(4);
    endtask

    task automatic t_level;
        wr(A0_EN, 32'h0040_0000);
        src_in[22] = 1'b1;
        idle(6);
        chk_irq(1'b1, 6'd22, "R6 level pending");
        chk_rd(A0_EV, 32'h0, "R6 level no event");
        wr(A0_ACK, 32'h0040_0000);
        idle(2);
        chk_irq(1'b1, 6'd22, "R6 ack ignored on level");
        src_in[22] = 1'b0;
        idle(6);
        chk_irq(1'b0, 6'd0, "R6 level released");
        wr(A0_EN, 32'h0);
    endtask

    task automatic t_regs;
        src_in[63:32] = 32'h1234_5678;
        idle(5);
        chk_rd(A1_LV, 32'h1234_5678, "R7 level read disabled sources");
        wr(A1_LV, 32'hFFFF_FFFF);
        chk_rd(A1_LV, 32'h1234_5678, "R11 level write ignored");
        wr(A1_EV, 32'hFFFF_FFFF);
        chk_rd(A1_EV, 32'h0, "R11 event write ignored");
        chk_rd(A1_ACK, 32'h0, "R11 ack reads zero");
        chk_rd(6'h00, 32'h0, "R11 unmapped reads zero");
        chk_rd(A0_LV, 32'h0, "R11 bank0 level at 0x2C");
        src_in[63:32] = '0;
        idle(5);
    endtask

    task automatic t_priority;
        wr(A0_EN, 32'hFFFF_FFFF);
        wr(A1_EN, 32'hFFFF_FFFF);
        src_in[10] = 1'b1; src_in[30] = 1'b1;
        idle(6);
        chk_irq(1'b1, 6'd30, "R8 highest bit in bank0");
        src_in[40] = 1'b1;
        idle(6);
        chk_irq(1'b1, 6'd40, "R8 upper bank first");
        wr(A1_ACK, 32'h100);
        idle(2);
        chk_irq(1'b1, 6'd30, "R8 back to bank0");
        wr(A0_ACK, 32'h4000_0000);
        idle(2);
        chk_irq(1'b1, 6'd10, "R8 next lower");
        src_in[25] = 1'b1;
        idle(5);
        chk_irq(1'b1, 6'd25, "R8 level outranks lower edge");
        src_in = '0;
        idle(4);
        wr(A0_ACK, 32'hFFFF_FFFF);
        wr(A1_ACK, 32'hFFFF_FFFF);
        wr(A0_EN, 32'h0);
        wr(A1_EN, 32'h0);
        idle(3);
        chk_irq(1'b0, 6'd0, "R9 nothing pending");
    endtask

    task automatic t_latency;
        src_in[21] = 1'b1;
        idle(5);
        chk_irq(1'b0, 6'd0, "R9 disabled level not pending");
        @(negedge clk);
        bus_addr = A0_EN; bus_wdata = 32'h0020_0000; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        chk(irq_idx_vld == 1'b0, "R12 not yet valid", 64'(irq_idx_vld), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk_irq(1'b1, 6'd21, "R12 valid one edge later");
        src_in[21] = 1'b0;
        wr(A0_EN, 32'h0);
        idle(4);
    endtask

    task automatic t_same_cycle;
        wr(A0_EN, 32'h4);
        src_in[2] = 1'b1;
        idle(6);
        src_in[2] = 1'b0;
        idle(6);
        @(negedge clk);
        src_in[2] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = A0_ACK; bus_wdata = 32'h4; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        chk_rd(A0_EV, 32'h4, "R10 edge survives same-cycle ack");
        chk_irq(1'b1, 6'd2, "R10 request kept");
        wr(A0_ACK, 32'h4);
        chk_rd(A0_EV, 32'h0, "R5 plain ack clears");
        src_in[2] = 1'b0;
        wr(A0_EN, 32'h0);
        idle(4);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_enable_rb();
        t_edge_ack();
        t_pre_high();
        t_level();
        t_regs();
        t_priority();
        t_latency();
        t_same_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule